// File: doc/BRIEF.md
# Biphase-Mark Two-Channel Audio Subframe Receiver

This block takes a serial two-channel audio stream in biphase-mark code and turns it into parallel words. The system clock oversamples the line, and one bit cell nominally lasts four clocks. The block finds where each subframe starts by looking for coding violations. Instead of sampling fixed slots, it measures the time between line edges and sorts each run into one of three classes:

- a half cell (about 2 clocks);
- a whole cell (about 4 clocks);
- a stretched run of one and a half cells (about 6 clocks), which never occurs inside data.

Every subframe opens with a preamble of four runs. The order of the run classes tells the three preambles apart: the first-channel start, the second-channel start and the block start. The block start also counts as a first-channel start. The block then collects 24 audio bits, least significant first, followed by 4 control bits.

When the last bit of a subframe arrives, the completed word is written into the held register of its channel and a one-cycle strobe is raised. A subframe that breaks the coding rules part way through is dropped, and decoding resumes at the next preamble. Both line polarities decode the same way, because only the spacing of edges matters.

Top module: `bmc_subframe_rx`

## Requirements
- R1: While reset is asserted, and until the first decoded event, every output reads zero.
- R2: Runs of 3, 3, 1 and 1 half cells form the first-channel preamble. The block raises `chan_start` for one cycle with `chan_sel`=0 and `block_start`=0. The pulse appears at the third clock edge after the line transition that closes the preamble first reaches the block.
- R3: Runs of 3, 2, 1 and 2 half cells form the second-channel preamble. The block raises `chan_start` with `chan_sel`=1 and the same latency as R2.
- R4: Runs of 3, 1, 1 and 3 half cells form the block preamble. The block raises `chan_start` and `block_start` together with `chan_sel`=0, and the subframe that follows is filed as first-channel data.
- R5: A preamble or bit sent with the opposite line level (the inverted pattern, used when the previous cell ended high) decodes exactly like its non-inverted form.
- R6: A data bit is 0 when its cell holds a single 4-clock run and 1 when the cell splits into two 2-clock runs. The first 24 bits after a preamble form the data word, with the first bit received at bit 0. The word goes to `left_word` after a first-channel or block preamble, and to `right_word` after a second-channel preamble.
- R7: The 4 bits after the data are presented on `ctrl_bits`, with the first one received at bit 0. `ctrl_bits` changes only when `word_valid` is high.
- R8: `word_valid` is a one-cycle pulse at the third clock edge after the transition that ends the last control bit reaches the block. `word_chan` is 0 for first-channel words and 1 for second-channel words. `word_valid` and `chan_start` are never high together.
- R9: `left_word` changes only when `word_valid` is high with `word_chan`=0, and `right_word` changes only when `word_valid` is high with `word_chan`=1.
- R10: A run longer than 7 clocks inside a subframe abandons that subframe, as does any run that does not fit the expected preamble or bit pattern. The abandoned subframe gives no `word_valid` and leaves all held registers unchanged, and the next preamble is decoded normally.
- R11: The serial input passes through a two-flop synchroniser before edge detection; that is what fixes the three-edge latency in R2 and R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, four per bit cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| bmc_in | input | 1 | Serial biphase-mark line |
| left_word | output | 24 | Held data of the last first-channel subframe |
| right_word | output | 24 | Held data of the last second-channel subframe |
| ctrl_bits | output | 4 | Control bits of the last completed subframe |
| word_valid | output | 1 | One-cycle strobe when a subframe completes |
| word_chan | output | 1 | Channel of the completed word (0 first, 1 second) |
| chan_start | output | 1 | One-cycle strobe when any preamble is recognised |
| chan_sel | output | 1 | Channel named by the last preamble (0 first, 1 second) |
| block_start | output | 1 | One-cycle strobe when a block preamble is recognised |

## Verification
The bench targets the runs where only the order of classes separates the three preambles. If the decoder confused the block start with a channel start, it would misreport `block_start`, or it would file the word into `right_word`. Subframes begin with both line levels, so a decoder that looked at levels rather than run lengths would lose every inverted preamble. Data words of all ones, all zeros and alternating bits check the half-cell pair versus whole-cell decision and the least-significant-first order; a reversed shift or an off-by-one bit count would scramble or shift the words. A subframe broken by a long gap must leave the held registers untouched; a decoder that kept counting through the gap would emit a corrupted word or swallow the next good subframe.

// File: rtl/bmc_rx_pkg.sv
package bmc_rx_pkg;

   // class of the run that just ended at a line edge
   typedef enum logic [1:0] {
      IV_HALF,
      IV_FULL,
      IV_LONG,
      IV_BAD
   } interval_e;

   // preamble kinds, told apart by their second run
   typedef enum logic [1:0] {
      PK_FIRST,
      PK_SECOND,
      PK_BLOCK
   } pre_kind_e;

   typedef enum logic [2:0] {
      ST_HUNT,
      ST_PRE1,
      ST_PRE2,
      ST_PRE3,
      ST_CELL,
      ST_MID
   } fr_state_e;

endpackage

// File: rtl/bmc_rx_sync.sv
module bmc_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES < 2) begin : g_stage_chk
         $error("bmc_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain[g] <= 1'b0;
            end else begin
               chain[g] <= (g == 0) ? din : chain[(g == 0) ? 0 : g - 1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/bmc_rx_interval.sv
module bmc_rx_interval
   import bmc_rx_pkg::*;
#(
   parameter int CELL_CLKS = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      level,
   output logic      edge_seen,
   output interval_e kind
);

   localparam int HALF     = CELL_CLKS / 2;
   localparam int LIM_HALF = HALF + HALF / 2;
   localparam int LIM_FULL = 2 * HALF + HALF / 2;
   localparam int LIM_LONG = 3 * HALF + HALF / 2;
   localparam int CNT_MAX  = LIM_LONG + 1;
   localparam int CNT_W    = $clog2(CNT_MAX + 1);

   generate
      if (CELL_CLKS < 4 || (CELL_CLKS % 2) != 0) begin : g_cell_chk
         $error("bmc_rx_interval: CELL_CLKS must be even and at least 4");
      end
   endgenerate

   logic             prev;
   logic [CNT_W-1:0] run;

   assign edge_seen = level ^ prev;

   // run length since the previous edge, saturating so idle lines read as bad
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= 1'b0;
         run  <= CNT_W'(CNT_MAX);
      end else begin
         prev <= level;
         if (edge_seen) begin
            run <= CNT_W'(1);
         end else if (run != CNT_W'(CNT_MAX)) begin
            run <= run + 1'b1;
         end
      end
   end

   always_comb begin
      if (run <= CNT_W'(LIM_HALF)) begin
         kind = IV_HALF;
      end else if (run <= CNT_W'(LIM_FULL)) begin
         kind = IV_FULL;
      end else if (run <= CNT_W'(LIM_LONG)) begin
         kind = IV_LONG;
      end else begin
         kind = IV_BAD;
      end
   end

endmodule

// File: rtl/bmc_rx_framer.sv
module bmc_rx_framer
   import bmc_rx_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int CTRL_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              edge_seen,
   input  interval_e         kind,
   output logic [DATA_W-1:0] left_word,
   output logic [DATA_W-1:0] right_word,
   output logic [CTRL_W-1:0] ctrl_bits,
   output logic              word_valid,
   output logic              word_chan,
   output logic              chan_start,
   output logic              chan_sel,
   output logic              block_start
);

   localparam int SF_BITS = DATA_W + CTRL_W;
   localparam int BCW     = $clog2(SF_BITS);

   generate
      if (DATA_W < 1 || CTRL_W < 1) begin : g_width_chk
         $error("bmc_rx_framer: DATA_W and CTRL_W must be positive");
      end
   endgenerate

   fr_state_e          st;
   pre_kind_e          pk;
   logic [SF_BITS-1:0] shreg;
   logic [BCW-1:0]     nbits;

   logic               bit_ok;
   logic               pre_done;
   logic [SF_BITS-1:0] next_sh;
   logic               last_bit;

   always_comb begin
      bit_ok   = (st == ST_CELL && kind == IV_FULL) ||
                 (st == ST_MID  && kind == IV_HALF);
      pre_done = (pk == PK_FIRST  && kind == IV_HALF) ||
                 (pk == PK_SECOND && kind == IV_FULL) ||
                 (pk == PK_BLOCK  && kind == IV_LONG);
      next_sh  = {(st == ST_MID), shreg[SF_BITS-1:1]};
      last_bit = (nbits == BCW'(SF_BITS - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_HUNT;
         pk          <= PK_FIRST;
         shreg       <= '0;
         nbits       <= '0;
         left_word   <= '0;
         right_word  <= '0;
         ctrl_bits   <= '0;
         word_valid  <= 1'b0;
         word_chan   <= 1'b0;
         chan_start  <= 1'b0;
         chan_sel    <= 1'b0;
         block_start <= 1'b0;
      end else begin
         word_valid  <= 1'b0;
         chan_start  <= 1'b0;
         block_start <= 1'b0;
         if (edge_seen) begin
            case (st)
               ST_HUNT: begin
                  if (kind == IV_LONG) st <= ST_PRE1;
               end
               ST_PRE1: begin
                  st <= ST_PRE2;
                  case (kind)
                     IV_LONG: pk <= PK_FIRST;
                     IV_HALF: pk <= PK_BLOCK;
                     IV_FULL: pk <= PK_SECOND;
                     default: st <= ST_HUNT;
                  endcase
               end
               ST_PRE2: begin
                  st <= (kind == IV_HALF) ? ST_PRE3 : ST_HUNT;
               end
               ST_PRE3: begin
                  if (pre_done) begin
                     st          <= ST_CELL;
                     nbits       <= '0;
                     chan_start  <= 1'b1;
                     block_start <= (pk == PK_BLOCK);
                     chan_sel    <= (pk == PK_SECOND);
                  end else begin
                     st <= ST_HUNT;
                  end
               end
               ST_CELL, ST_MID: begin
                  if (bit_ok) begin
                     shreg <= next_sh;
                     nbits <= nbits + 1'b1;
                     if (last_bit) begin
                        st         <= ST_HUNT;
                        word_valid <= 1'b1;
                        word_chan  <= (pk == PK_SECOND);
                        ctrl_bits  <= next_sh[SF_BITS-1:DATA_W];
                        if (pk == PK_SECOND) begin
                           right_word <= next_sh[DATA_W-1:0];
                        end else begin
                           left_word <= next_sh[DATA_W-1:0];
                        end
                     end else begin
                        st <= ST_CELL;
                     end
                  end else if (st == ST_CELL && kind == IV_HALF) begin
                     st <= ST_MID;
                  end else begin
                     st <= ST_HUNT;
                  end
               end
               default: st <= ST_HUNT;
            endcase
         end
      end
   end

endmodule

// File: rtl/bmc_subframe_rx.sv
module bmc_subframe_rx
   import bmc_rx_pkg::*;
#(
   parameter int CELL_CLKS   = 4,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 24,
   parameter int CTRL_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bmc_in,
   output logic [DATA_W-1:0] left_word,
   output logic [DATA_W-1:0] right_word,
   output logic [CTRL_W-1:0] ctrl_bits,
   output logic              word_valid,
   output logic              word_chan,
   output logic              chan_start,
   output logic              chan_sel,
   output logic              block_start
);

   logic      line_lvl;
   logic      edge_seen;
   interval_e run_kind;

   bmc_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (bmc_in),
      .dout (line_lvl)
   );

   bmc_rx_interval #(.CELL_CLKS(CELL_CLKS)) i_interval (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (line_lvl),
      .edge_seen(edge_seen),
      .kind     (run_kind)
   );

   bmc_rx_framer #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) i_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .edge_seen  (edge_seen),
      .kind       (run_kind),
      .left_word  (left_word),
      .right_word (right_word),
      .ctrl_bits  (ctrl_bits),
      .word_valid (word_valid),
      .word_chan  (word_chan),
      .chan_start (chan_start),
      .chan_sel   (chan_sel),
      .block_start(block_start)
   );

endmodule

// File: rtl/bmc_subframe_rx_chk.sv
module bmc_subframe_rx_chk #(
   parameter int DATA_W = 24,
   parameter int CTRL_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] left_word,
   input logic [DATA_W-1:0] right_word,
   input logic [CTRL_W-1:0] ctrl_bits,
   input logic              word_valid,
   input logic              word_chan,
   input logic              chan_start,
   input logic              chan_sel,
   input logic              block_start
);

   // R8
   wv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   // R8
   wv_cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> !chan_start);

   // R2
   cs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_start |=> !chan_start);

   // R4
   blk_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      block_start |-> (chan_start && !chan_sel));

   // R9
   left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(left_word) |-> (word_valid && !word_chan));

   // R9
   right_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(right_word) |-> (word_valid && word_chan));

   // R7
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_bits) |-> word_valid);

endmodule

bind bmc_subframe_rx bmc_subframe_rx_chk #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .left_word  (left_word),
   .right_word (right_word),
   .ctrl_bits  (ctrl_bits),
   .word_valid (word_valid),
   .word_chan  (word_chan),
   .chan_start (chan_start),
   .chan_sel   (chan_sel),
   .block_start(block_start)
);

// File: tb/test_bmc_subframe_rx.sv
`timescale 1ns/1ps
module test_bmc_subframe_rx;

   localparam int HALF_SMP = 2;
   localparam int LAT      = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bmc_in = 1'b0;
   logic [23:0] left_word, right_word;
   logic [3:0]  ctrl_bits;
   logic        word_valid, word_chan, chan_start, chan_sel, block_start;

   always #2 clk = ~clk;

   bmc_subframe_rx i_bmc_subframe_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .bmc_in     (bmc_in),
      .left_word  (left_word),
      .right_word (right_word),
      .ctrl_bits  (ctrl_bits),
      .word_valid (word_valid),
      .word_chan  (word_chan),
      .chan_start (chan_start),
      .chan_sel   (chan_sel),
      .block_start(block_start)
   );

   // event kinds: 0 preamble recognised, 1 word complete; ch 0 first, 1 second, 2 block
   typedef struct {
      int          t;
      int          kind;
      int          ch;
      logic [23:0] d;
      logic [3:0]  c;
   } ev_s;

   ev_s         evq[$];
   bit          stim[$];
   int          ph_t[$];
   string       ph_s[$];
   bit          cur = 1'b0;
   bit          pend = 1'b0;
   int          pend_ch;
   logic [23:0] pend_d;
   logic [3:0]  pend_c;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   string phase = "R1 reset";

   function automatic void put(bit v);
      ev_s e;
      if (v != cur && pend) begin
         e.t = stim.size(); e.kind = 1; e.ch = pend_ch; e.d = pend_d; e.c = pend_c;
         evq.push_back(e);
         pend = 1'b0;
      end
      cur = v;
      stim.push_back(v);
   endfunction

   function automatic void put_half(bit v);
      for (int i = 0; i < HALF_SMP; i++) put(v);
   endfunction

   function automatic void hold(int n);
      for (int i = 0; i < n; i++) put(cur);
   endfunction

   function automatic void mark(string s);
      ph_t.push_back(stim.size());
      ph_s.push_back(s);
   endfunction

   // one subframe; gap_at >= 0 inserts a coding violation before that bit
   function automatic void subframe(int ch, logic [23:0] d, logic [3:0] c, int gap_at);
      logic [7:0] pat;
      bit         inv;
      ev_s        e;
      pat = (ch == 0) ? 8'b11100010 : (ch == 1) ? 8'b11100100 : 8'b11101000;
      inv = cur;
      for (int i = 7; i >= 0; i--) put_half(pat[i] ^ inv);
      e.t = stim.size(); e.kind = 0; e.ch = ch; e.d = '0; e.c = '0;
      evq.push_back(e);
      for (int b = 0; b < 28; b++) begin
         bit bv;
         bv = (b < 24) ? d[b] : c[b-24];
         if (b == gap_at) hold(12);
         put_half(~cur);
         put_half(bv ? ~cur : cur);
      end
      if (gap_at < 0) begin
         pend = 1'b1; pend_ch = ch; pend_d = d; pend_c = c;
      end
   endfunction

   function automatic void end_stream();
      put(~cur);
      hold(14);
   endfunction

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp, int cyc);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s [%s] cycle %0d: actual %0h expected %0h",
                  tag, what, phase, cyc, act, exp);
      end
   endtask

   logic [23:0] e_left = '0, e_right = '0;
   logic [3:0]  e_ctrl = '0;
   logic        e_wv, e_wch = 1'b0, e_cs, e_sel = 1'b0, e_bs;

   task automatic compare_all(int cyc);
      chk(left_word === e_left,     "R6 R9", "left_word",  32'(left_word),  32'(e_left),  cyc);
      chk(right_word === e_right,   "R6 R9", "right_word", 32'(right_word), 32'(e_right), cyc);
      chk(ctrl_bits === e_ctrl,     "R7",    "ctrl_bits",  32'(ctrl_bits),  32'(e_ctrl),  cyc);
      chk(word_valid === e_wv,      "R8",    "word_valid", 32'(word_valid), 32'(e_wv),    cyc);
      chk(word_chan === e_wch,      "R8",    "word_chan",  32'(word_chan),  32'(e_wch),   cyc);
      chk(chan_start === e_cs,      "R2",    "chan_start", 32'(chan_start), 32'(e_cs),    cyc);
      chk(chan_sel === e_sel,       "R3",    "chan_sel",   32'(chan_sel),   32'(e_sel),   cyc);
      chk(block_start === e_bs,     "R4",    "block_start",32'(block_start),32'(e_bs),    cyc);
   endtask

   initial begin
      int ei;
      int pi;
      int total;
      // stream 1: mixed kinds, three-edge latency
      mark("R11 mixed stream");
      hold(10);
      subframe(2, 24'h123456, 4'h5, -1);
      subframe(1, 24'hABCDEF, 4'hA, -1);
      subframe(0, 24'h0F1E2D, 4'h3, -1);
      subframe(1, 24'h800001, 4'hC, -1);
      end_stream();
      // stream 2: idle high so the first preamble is the inverted form
      mark("R5 inverted polarity");
      if (cur == 1'b0) put(1'b1);
      hold(10);
      subframe(0, 24'h5A5A5A, 4'h9, -1);
      subframe(1, 24'hC3C3C3, 4'h6, -1);
      subframe(2, 24'h000F00, 4'h1, -1);
      subframe(1, 24'h7FFFFE, 4'hE, -1);
      end_stream();
      // stream 3: second subframe broken by a long gap
      mark("R10 violation");
      hold(10);
      subframe(0, 24'h111111, 4'h2, -1);
      subframe(1, 24'hBADBAD, 4'hF, 10);
      subframe(0, 24'h222222, 4'h4, -1);
      subframe(1, 24'h333333, 4'h8, -1);
      end_stream();
      // stream 4: boundary data patterns
      mark("R6 boundary data");
      hold(10);
      subframe(0, 24'hFFFFFF, 4'hF, -1);
      subframe(1, 24'h000000, 4'h0, -1);
      subframe(2, 24'hAAAAAA, 4'h5, -1);
      subframe(1, 24'h555555, 4'hA, -1);
      end_stream();

      // R1: outputs during reset
      e_wv = 1'b0; e_cs = 1'b0; e_bs = 1'b0;
      for (int r = 0; r < 3; r++) begin
         @(negedge clk);
         compare_all(-1);
      end

      ei = 0;
      pi = 0;
      total = stim.size() + 8;
      for (int n = 0; n < total; n++) begin
         @(negedge clk);
         if (n == 0) rst_n = 1'b1;
         while (pi < ph_t.size() && ph_t[pi] <= n - LAT) begin
            phase = ph_s[pi];
            pi++;
         end
         e_wv = 1'b0; e_cs = 1'b0; e_bs = 1'b0;
         while (ei < evq.size() && evq[ei].t == n - LAT) begin
            if (evq[ei].kind == 0) begin
               e_cs  = 1'b1;
               e_bs  = (evq[ei].ch == 2);
               e_sel = (evq[ei].ch == 1);
            end else begin
               e_wv   = 1'b1;
               e_wch  = (evq[ei].ch == 1);
               e_ctrl = evq[ei].c;
               if (evq[ei].ch == 1) e_right = evq[ei].d;
               else                 e_left  = evq[ei].d;
            end
            ei++;
         end
         compare_all(n);
         bmc_in = (n < stim.size()) ? stim[n] : cur;
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual running expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule